// File: doc/BRIEF.md
# Configurable Sum-of-Products Macrocell Array

This block is a small universal logic array. A bank of AND-plane cells builds product terms from the true and inverted forms of a set of dedicated inputs and of one feedback signal per output cell. Each output cell ORs its own group of product terms and then passes the result through an output stage. Two global mode bits and two local bits per cell set that stage: registered, combinatorial with a term-driven enable, dedicated combinatorial output, or dedicated input. Each pin is modelled as a separate input value (`pin_in`), output value (`pin_out`) and drive enable (`pin_oe`).

The whole configuration is one long vector. It is shifted in serially into a shadow copy and becomes active only when a commit strobe arrives after exactly the right number of bits. A loader state machine has three states. `LD_IDLE` is the rest state. `LD_LOAD` accepts shift bits and the commit. `LD_READ` streams the active pattern out one bit per cycle. The transitions are as follows. `LD_IDLE` goes to `LD_LOAD` when a shift bit is offered, which takes priority over a read request. `LD_IDLE` goes to `LD_READ` on a read request. `LD_LOAD` returns to `LD_IDLE` on commit. `LD_READ` returns to `LD_IDLE` after the last bit. A protection bit masks the readback stream. Register preload for test access still works when that bit is set.

Top module: `sop_macro_array`

## Requirements
- R1: The configuration is W = N_CELL*N_PT*2*(N_IN+N_CELL) + 2*N_CELL + 3 bits, shifted in on `cfg_din` while `cfg_shift` is high, one bit per cycle, first bit landing at index 0. A `cfg_commit` pulse after exactly W shift cycles makes the pattern active from the next cycle. Index layout from 0 upward: AND-plane cells, then N_CELL mode-select bits (`lsel`), then N_CELL polarity bits (`pol`), then global bit `g0`, then `g1`, then the protect bit at index W-1.
- R2: A commit after fewer or more than W shift bits, or a commit while idle, leaves the active pattern and all outputs unchanged.
- R3: Term t of cell c uses the AND-plane cells at index (c*N_PT+t)*2*(N_IN+N_CELL) + col. Signal k is `din[k]` for k < N_IN and the feedback of cell k-N_IN otherwise. col 2k selects the true form and 2k+1 the inverted form. The term is the AND of its selected forms, and is 0 when none is selected.
- R4: With `g1`=0 a cell is a dedicated output unless it is a dedicated input. It is always driven, and its value is the OR of all N_PT terms, passed through when `pol`=1 and inverted when `pol`=0.
- R5: With `g1`=0 and `lsel`=1 a cell is a dedicated input: `pin_oe`=0, `pin_out`=0, and `pin_in` is its feedback. Cells NOFB_A and NOFB_B cannot be inputs and stay dedicated outputs. Their feedback reads 0 in every non-registered mode.
- R6: With `g1`=1, `g0`=0 and `lsel`=0 a cell is registered. `pin_oe` follows `reg_oe`. The pin value after a clock edge is the OR of all terms with the `pol` rule, the pin reads the inverse of the flop, and the feedback is the flop.
- R7: With `g1`=1 and either `g0`=1 or `lsel`=1 a cell is combinatorial I/O. Term 0 drives `pin_oe`, the value is the OR of terms 1..N_PT-1 with the `pol` rule, and the feedback is `pin_in`.
- R8: After reset the active pattern is all zero, the loader is idle with `rd_valid`=0, and every cell is a driven dedicated output reading 1.
- R9: `preload_en` loads `preload_data` into the flops at the next edge, overriding the terms. A registered pin then reads the inverse of the loaded bit for either polarity, also with the protect bit set.
- R10: A `rd_req` pulse while idle gives W cycles of `rd_valid`=1, with `rd_dout` carrying active bit i in the i-th cycle. When the protect bit is set, every streamed bit reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_shift | input | 1 | Shift one configuration bit this cycle |
| cfg_din | input | 1 | Serial configuration bit |
| cfg_commit | input | 1 | Apply the shifted pattern |
| rd_req | input | 1 | Start a readback of the active pattern |
| rd_dout | output | 1 | Readback bit |
| rd_valid | output | 1 | Readback bit is valid |
| din | input | N_IN | Dedicated array inputs |
| reg_oe | input | 1 | Output enable for registered cells |
| preload_en | input | 1 | Force the flops from `preload_data` |
| preload_data | input | N_CELL | Preload values |
| pin_in | input | N_CELL | Value present at each cell's pin |
| pin_out | output | N_CELL | Value driven by each cell (0 when not enabled) |
| pin_oe | output | N_CELL | Drive enable of each cell |

## Verification
The bench builds the array with N_IN=2, N_PT=4 and N_CELL=8. This gives a 659-bit pattern, so a full serial load, a short load and a full readback each take well under a thousand cycles. In each configuration the sweep covers all 256 flop states against every dedicated-input value and a varied spread of pin values. The expected pins and next flop values are derived arithmetically from the pattern the bench itself assembled. Five patterns cover the simple, registered-mixed and all-combinatorial families, plus the protected case.

// File: rtl/sop_pkg.sv
package sop_pkg;

    typedef enum logic [1:0] {
        LD_IDLE,
        LD_LOAD,
        LD_READ
    } ld_state_e;

    typedef enum logic [1:0] {
        CM_DED_OUT,
        CM_DED_IN,
        CM_REG,
        CM_COMB_IO
    } cell_mode_e;

endpackage

// File: rtl/sop_cfg_loader.sv
module sop_cfg_loader
    import sop_pkg::*;
#(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_shift,
    input  logic         cfg_din,
    input  logic         cfg_commit,
    input  logic         rd_req,
    output logic [W-1:0] active,
    output logic         rd_dout,
    output logic         rd_valid
);
    localparam int CW = $clog2(W + 2);
    localparam int IW = $clog2(W);
    localparam logic [CW-1:0] CNT_FULL = CW'(W);
    localparam logic [CW-1:0] CNT_SAT  = CW'(W + 1);
    localparam logic [IW-1:0] IDX_LAST = IW'(W - 1);

    ld_state_e     state, state_nx;
    logic [W-1:0]  shadow;
    logic [CW-1:0] cnt;
    logic [IW-1:0] idx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LD_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            LD_IDLE: begin
                if (cfg_shift)   state_nx = LD_LOAD;
                else if (rd_req) state_nx = LD_READ;
            end
            LD_LOAD: if (cfg_commit) state_nx = LD_IDLE;
            LD_READ: if (idx == IDX_LAST) state_nx = LD_IDLE;
            default: state_nx = LD_IDLE;
        endcase
    end

    // shadow, bit counter, readback index and active pattern
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow <= '0;
            cnt    <= '0;
            idx    <= '0;
            active <= '0;
        end else begin
            unique case (state)
                LD_IDLE: begin
                    idx <= '0;
                    cnt <= '0;
                    if (cfg_shift) begin
                        shadow <= {cfg_din, shadow[W-1:1]};
                        cnt    <= CW'(1);
                    end
                end
                LD_LOAD: begin
                    if (cfg_commit) begin
                        if (cnt == CNT_FULL) active <= shadow;
                        cnt <= '0;
                    end else if (cfg_shift) begin
                        shadow <= {cfg_din, shadow[W-1:1]};
                        if (cnt != CNT_SAT) cnt <= cnt + CW'(1);
                    end
                end
                LD_READ: idx <= (idx == IDX_LAST) ? '0 : idx + IW'(1);
                default: cnt <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        rd_valid = (state == LD_READ);
        rd_dout  = rd_valid & (active[W-1] | active[idx]);
    end

    assert_idle_commit_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LD_IDLE && cfg_commit && !cfg_shift) |=> $stable(active));

    assert_read_needs_request_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> $past(rd_req));

    assert_protected_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && active[W-1]) |-> rd_dout);

endmodule

// File: rtl/sop_and_array.sv
module sop_and_array #(
    parameter int N_IN   = 8,
    parameter int N_CELL = 8,
    parameter int N_PT   = 8
) (
    input  logic [N_IN-1:0]                          din,
    input  logic [N_CELL-1:0]                        fb,
    input  logic [N_CELL*N_PT*2*(N_IN+N_CELL)-1:0]   plane,
    output logic [N_CELL*N_PT-1:0]                   pts
);
    localparam int NSIG = N_IN + N_CELL;
    localparam int NCOL = 2 * NSIG;
    localparam int NROW = N_CELL * N_PT;

    logic [NSIG-1:0] sig;
    logic [NCOL-1:0] lits;

    assign sig = {fb, din};

    always_comb begin
        for (int k = 0; k < NSIG; k++) begin
            lits[2*k]   = sig[k];
            lits[2*k+1] = ~sig[k];
        end
    end

    for (genvar r = 0; r < NROW; r++) begin : g_row
        logic [NCOL-1:0] sel;
        assign sel    = plane[r*NCOL +: NCOL];
        // a row with nothing selected stays low; otherwise no selected literal may be 0
        assign pts[r] = (|sel) & ~(|(sel & ~lits));
    end

endmodule

// File: rtl/sop_macrocell.sv
module sop_macrocell
    import sop_pkg::*;
#(
    parameter int N_PT  = 8,
    parameter bit NO_FB = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_PT-1:0] pts,
    input  logic            g0,
    input  logic            g1,
    input  logic            lsel,
    input  logic            pol,
    input  logic            reg_oe,
    input  logic            preload_en,
    input  logic            preload_bit,
    input  logic            pin_in,
    output logic            pin_out,
    output logic            pin_oe,
    output logic            fb
);
    cell_mode_e mode;
    logic       q;
    logic       sum_all;
    logic       sum_tail;
    logic       val;

    always_comb begin
        if (!g1)              mode = (lsel && !NO_FB) ? CM_DED_IN : CM_DED_OUT;
        else if (!g0 && !lsel) mode = CM_REG;
        else                  mode = CM_COMB_IO;
    end

    assign sum_all  = |pts;
    assign sum_tail = |pts[N_PT-1:1];

    // flop holds the inverse of the pin value; reset low makes the pin read high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          q <= 1'b0;
        else if (preload_en) q <= preload_bit;
        else                 q <= pol ? ~sum_all : sum_all;
    end

    assign fb = (mode == CM_REG) ? q : (NO_FB ? 1'b0 : pin_in);

    always_comb begin
        unique case (mode)
            CM_DED_OUT: begin pin_oe = 1'b1;   val = pol ? sum_all : ~sum_all;   end
            CM_DED_IN:  begin pin_oe = 1'b0;   val = 1'b0;                       end
            CM_REG:     begin pin_oe = reg_oe; val = ~q;                         end
            CM_COMB_IO: begin pin_oe = pts[0]; val = pol ? sum_tail : ~sum_tail; end
            default:    begin pin_oe = 1'b0;   val = 1'b0;                       end
        endcase
        pin_out = pin_oe & val;
    end

    assert_preload_loads_R9: assert property (@(posedge clk) disable iff (!rst_n)
        preload_en |=> (q == $past(preload_bit)));

    assert_dedicated_input_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!g1 && lsel && !NO_FB) |-> (!pin_oe && !pin_out));

    assert_registered_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (g1 && !g0 && !lsel) |-> (pin_oe == reg_oe));

endmodule

// File: rtl/sop_macro_array.sv
module sop_macro_array
    import sop_pkg::*;
#(
    parameter int N_IN   = 8,
    parameter int N_CELL = 8,
    parameter int N_PT   = 8,
    parameter int NOFB_A = 3,
    parameter int NOFB_B = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_shift,
    input  logic              cfg_din,
    input  logic              cfg_commit,
    input  logic              rd_req,
    output logic              rd_dout,
    output logic              rd_valid,
    input  logic [N_IN-1:0]   din,
    input  logic              reg_oe,
    input  logic              preload_en,
    input  logic [N_CELL-1:0] preload_data,
    input  logic [N_CELL-1:0] pin_in,
    output logic [N_CELL-1:0] pin_out,
    output logic [N_CELL-1:0] pin_oe
);
    localparam int NCOL  = 2 * (N_IN + N_CELL);
    localparam int F     = N_CELL * N_PT * NCOL;
    localparam int W     = F + 2 * N_CELL + 3;

    logic [W-1:0]             active;
    logic [N_CELL-1:0]        fb;
    logic [N_CELL*N_PT-1:0]   pts;
    logic [N_CELL-1:0]        lsel;
    logic [N_CELL-1:0]        pol;
    logic                     g0;
    logic                     g1;

    assign lsel = active[F +: N_CELL];
    assign pol  = active[F + N_CELL +: N_CELL];
    assign g0   = active[W-3];
    assign g1   = active[W-2];

    sop_cfg_loader #(.W(W)) u_loader (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_shift  (cfg_shift),
        .cfg_din    (cfg_din),
        .cfg_commit (cfg_commit),
        .rd_req     (rd_req),
        .active     (active),
        .rd_dout    (rd_dout),
        .rd_valid   (rd_valid)
    );

    sop_and_array #(.N_IN(N_IN), .N_CELL(N_CELL), .N_PT(N_PT)) u_plane (
        .din   (din),
        .fb    (fb),
        .plane (active[F-1:0]),
        .pts   (pts)
    );

    for (genvar c = 0; c < N_CELL; c++) begin : g_cell
        localparam bit NF = (c == NOFB_A) || (c == NOFB_B);
        sop_macrocell #(.N_PT(N_PT), .NO_FB(NF)) u_cell (
            .clk         (clk),
            .rst_n       (rst_n),
            .pts         (pts[c*N_PT +: N_PT]),
            .g0          (g0),
            .g1          (g1),
            .lsel        (lsel[c]),
            .pol         (pol[c]),
            .reg_oe      (reg_oe),
            .preload_en  (preload_en),
            .preload_bit (preload_data[c]),
            .pin_in      (pin_in[c]),
            .pin_out     (pin_out[c]),
            .pin_oe      (pin_oe[c]),
            .fb          (fb[c])
        );
    end

endmodule

// File: tb/sop_macro_array_test.sv
`timescale 1ns/1ps
module sop_macro_array_test;
    localparam int NI   = 2;
    localparam int NC   = 8;
    localparam int NP   = 4;
    localparam int NCOL = 2 * (NI + NC);
    localparam int F    = NC * NP * NCOL;
    localparam int W    = F + 2 * NC + 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_shift = 1'b0, cfg_din = 1'b0, cfg_commit = 1'b0, rd_req = 1'b0;
    logic rd_dout, rd_valid;
    logic [NI-1:0] din = '0;
    logic reg_oe = 1'b0, preload_en = 1'b0;
    logic [NC-1:0] preload_data = '0, pin_in = '0;
    logic [NC-1:0] pin_out, pin_oe;

    logic [W-1:0] cfg, act, rb;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sop_macro_array #(.N_IN(NI), .N_CELL(NC), .N_PT(NP), .NOFB_A(3), .NOFB_B(4)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_shift(cfg_shift), .cfg_din(cfg_din),
        .cfg_commit(cfg_commit), .rd_req(rd_req), .rd_dout(rd_dout), .rd_valid(rd_valid),
        .din(din), .reg_oe(reg_oe), .preload_en(preload_en), .preload_data(preload_data),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(input string req, input logic [31:0] actual, input logic [31:0] expv);
        checks++;
        if (actual !== expv) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, actual, expv);
        end
    endtask

    function automatic bit nofb(input int c);
        return (c == 3) || (c == 4);
    endfunction

    // 0 dedicated output, 1 dedicated input, 2 registered, 3 combinatorial I/O
    function automatic int cmode(input int c);
        logic g0, g1, ls;
        g0 = act[W-3]; g1 = act[W-2]; ls = act[F+c];
        if (!g1) return (ls && !nofb(c)) ? 1 : 0;
        if (!g0 && !ls) return 2;
        return 3;
    endfunction

    function automatic logic term(input int c, input int t, input logic [NI+NC-1:0] s);
        logic any, v;
        any = 1'b0; v = 1'b1;
        for (int k = 0; k < NI + NC; k++) begin
            if (act[(c*NP+t)*NCOL + 2*k])   begin any = 1'b1; v = v & s[k];  end
            if (act[(c*NP+t)*NCOL + 2*k+1]) begin any = 1'b1; v = v & ~s[k]; end
        end
        return any & v;
    endfunction

    task automatic model(input logic [NI-1:0] d, input logic [NC-1:0] p, input logic [NC-1:0] q,
                         input logic oe_in, output logic [NC-1:0] eo, output logic [NC-1:0] eoe,
                         output logic [NC-1:0] qn);
        logic [NC-1:0] fbv;
        logic all, tail, pl, v;
        for (int c = 0; c < NC; c++)
            fbv[c] = (cmode(c) == 2) ? q[c] : (nofb(c) ? 1'b0 : p[c]);
        for (int c = 0; c < NC; c++) begin
            all = 1'b0; tail = 1'b0;
            for (int t = 0; t < NP; t++) begin
                all = all | term(c, t, {fbv, d});
                if (t > 0) tail = tail | term(c, t, {fbv, d});
            end
            pl = act[F+NC+c];
            qn[c] = pl ? ~all : all;
            case (cmode(c))
                0: begin eoe[c] = 1'b1;  v = pl ? all : ~all; end
                1: begin eoe[c] = 1'b0;  v = 1'b0; end
                2: begin eoe[c] = oe_in; v = ~q[c]; end
                default: begin eoe[c] = term(c, 0, {fbv, d}); v = pl ? tail : ~tail; end
            endcase
            eo[c] = eoe[c] & v;
        end
    endtask

    task automatic build(input int seedv, input logic [NC-1:0] l0, input logic [NC-1:0] l1,
                         input logic g0, input logic g1, input logic sec);
        int h;
        cfg = '0;
        for (int c = 0; c < NC; c++)
            for (int t = 0; t < NP; t++)
                for (int k = 0; k < NI + NC; k++) begin
                    h = ((c*37 + t*11 + k*5 + seedv*23) ^ (k*c + t*seedv)) % 7;
                    if (h == 0)      cfg[(c*NP+t)*NCOL + 2*k]   = 1'b1;
                    else if (h == 1) cfg[(c*NP+t)*NCOL + 2*k+1] = 1'b1;
                end
        cfg[F +: NC] = l0;
        cfg[F+NC +: NC] = l1;
        cfg[W-3] = g0; cfg[W-2] = g1; cfg[W-1] = sec;
    endtask

    task automatic shift_in(input int nbits);
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk); cfg_shift = 1'b1; cfg_din = cfg[i % W];
        end
        @(negedge clk); cfg_shift = 1'b0; cfg_commit = 1'b1;
        @(negedge clk); cfg_commit = 1'b0;
    endtask

    task automatic read_back();
        @(negedge clk); rd_req = 1'b1;
        @(negedge clk); rd_req = 1'b0;
        for (int i = 0; i < W; i++) begin
            rb[i] = rd_dout;
            if (!rd_valid) rb[i] = 1'bx;
            @(negedge clk);
        end
        chk("R10 valid ends", 32'(rd_valid), 32'd0);
    endtask

    task automatic sweep(input string tag);
        logic [NC-1:0] eo, eoe, qn, qn2;
        for (int i = 0; i < 1024; i++) begin
            @(negedge clk);
            preload_en = 1'b1; preload_data = i[7:0]; din = i[9:8];
            pin_in = 8'(i*37 + 11); reg_oe = i[3] ^ i[9];
            @(negedge clk);
            model(din, pin_in, i[7:0], reg_oe, eo, eoe, qn);
            chk({tag, " pin_out"}, 32'(pin_out), 32'(eo));
            chk({tag, " pin_oe"}, 32'(pin_oe), 32'(eoe));
            preload_en = 1'b0;
            @(negedge clk);
            model(din, pin_in, qn, reg_oe, eo, eoe, qn2);
            chk({tag, " after edge"}, 32'(pin_out), 32'(eo));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        act = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state
        chk("R8 pin_out", 32'(pin_out), 32'hff);
        chk("R8 pin_oe", 32'(pin_oe), 32'hff);
        chk("R8 rd_valid", 32'(rd_valid), 32'd0);
        read_back();
        chk("R8 pattern zero", 32'($countones(rb)), 32'd0);

        // R1, R3, R4, R5: simple family, mixed dedicated inputs, cells 3/4 forced outputs
        build(1, 8'b1001_1010, 8'b0101_0110, 1'b1, 1'b0, 1'b0);
        shift_in(W); act = cfg;
        read_back();
        chk("R1 loaded pattern", 32'(rb == cfg), 32'd1);
        sweep("R3 R4 R5 simple");

        // R6, R7, R9: registered family with some combinatorial I/O cells
        build(2, 8'b0011_0100, 8'b1100_1010, 1'b0, 1'b1, 1'b0);
        shift_in(W); act = cfg;
        sweep("R6 R7 R9 registered");

        // R7: combinatorial family forces every cell to combinatorial I/O
        build(3, 8'b0000_0000, 8'b0110_1001, 1'b1, 1'b1, 1'b0);
        shift_in(W); act = cfg;
        sweep("R7 combinatorial");
        read_back();
        chk("R10 unprotected readback", 32'(rb == act), 32'd1);

        // R2: short load, long load and idle commit are all ignored
        build(9, 8'b1111_0000, 8'b1010_0101, 1'b0, 1'b1, 1'b0);
        shift_in(W - 1);
        read_back();
        chk("R2 short load ignored", 32'(rb == act), 32'd1);
        shift_in(W + 1);
        read_back();
        chk("R2 long load ignored", 32'(rb == act), 32'd1);
        @(negedge clk); cfg_commit = 1'b1;
        @(negedge clk); cfg_commit = 1'b0;
        read_back();
        chk("R2 idle commit ignored", 32'(rb == act), 32'd1);
        sweep("R2 outputs unchanged");

        // R9, R10: all registered, protect bit set
        build(4, 8'b0000_0000, 8'b0101_0101, 1'b0, 1'b1, 1'b1);
        shift_in(W); act = cfg;
        sweep("R9 preload under protection");
        read_back();
        chk("R10 protected readback ones", 32'($countones(rb)), 32'(W));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule